// File: doc/BRIEF.md
# Byte-Accessed 16-bit Compare Timer

This block is a 16-bit up-counter with two 16-bit compare channels, A and B, placed on an 8-bit register bus. Each 16-bit value (the counter and the two compare words) sits behind a low-byte address and a high-byte address. One 8-bit holding byte, shared by all three words, lets software move both halves of a word in a single clock. On a write, the high byte goes to the holding byte first, and the low-byte write then commits all 16 bits. On a read, the low byte is read first, and that read copies the high half into the holding byte. A read of any high-byte address returns the holding byte.

The counter steps once on every cycle where the timer-tick input is high. Each channel compares its word with the counter on every tick. On a match, the channel toggles its waveform pin and sets a sticky flag. A flag is cleared by writing a one to its bit, and each channel's interrupt output is its flag gated by an enable bit. When software writes the counter, compare matches are removed on the next tick in both channels, so a reload cannot fire a spurious event.

Top module: `cmpTimer16`

## Requirements
- R1: After reset, the counter, both compare words, the holding byte, the flag register, the enable register, both waveform pins and both interrupt outputs are all zero.
- R2: On each cycle with `timerTick` high and no counter write, the counter increments by one and wraps from 0xFFFF to 0x0000. With `timerTick` low, it holds.
- R3: A write to a high-byte address (1 counter, 3 channel A, 5 channel B) loads only the holding byte. A write to the matching low-byte address (0, 2, 4) loads {holding byte, written byte} into that word in one clock. A high-byte write alone leaves every word unchanged.
- R4: A read of a low-byte address returns bits 7:0 of the word in that same cycle and copies bits 15:8 into the holding byte. A read of any high-byte address returns the holding byte, so a low-then-high read gives a consistent snapshot even while the counter runs.
- R5: There is one holding byte for all three words. A high-byte write or low-byte read aimed at one word supplies the high half used by a later access to another word.
- R6: A counter write takes priority over a tick in the same cycle. The counter takes the written value and does not increment.
- R7: On a tick with no counter write and no pending block, a channel whose compare word equals the counter sets its flag and toggles its waveform pin.
- R8: A counter write blocks compare matches in both channels on the first tick after the write.
- R9: The flag register at address 6 holds channel A in bit 0 and channel B in bit 1. Writing a one to a bit clears that flag, and writing a zero has no effect. If a match and a clear hit the same flag in the same cycle, the flag ends up set.
- R10: The enable register at address 7 (bit 0 for A, bit 1 for B) can be read and written. Each interrupt output is high exactly when its flag and its enable bit are both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| timerTick | input | 1 | Timer clock enable; one counter step per high cycle |
| busAddr | input | 3 | Register address |
| busWr | input | 1 | Write strobe |
| busRd | input | 1 | Read strobe |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data, valid in the cycle busRd is high |
| waveA | output | 1 | Channel A waveform, toggles on each A match |
| waveB | output | 1 | Channel B waveform, toggles on each B match |
| irqA | output | 1 | Channel A interrupt request |
| irqB | output | 1 | Channel B interrupt request |

## Verification
The hardest situations to reach from the ports are the ones that need two events in the same clock. The first is a match on the blocked tick that follows a counter write. The stimulus loads the counter with a value equal to both compare words, so the very next tick would match if nothing blocked it. The second is a flag clear that coincides with a match. The stimulus writes the counter two steps below the compare value, lets the blocked tick and one free tick pass, and issues the clear on the exact tick where the match fires. The atomic snapshot is checked by reading the low byte on a tick cycle just before a carry into the high byte.

// File: rtl/cmpTimerPkg.sv
package cmpTimerPkg;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 2 * BYTE_W;
  localparam int NUM_CH = 2;
  localparam int ADDR_W = 3;
  localparam int NUM_WORDS = NUM_CH + 1;
  localparam int SEL_W = $clog2(NUM_WORDS);

  typedef enum logic [ADDR_W-1:0] {
    ADR_CNT_LO = 3'd0,
    ADR_CNT_HI = 3'd1,
    ADR_A_LO   = 3'd2,
    ADR_A_HI   = 3'd3,
    ADR_B_LO   = 3'd4,
    ADR_B_HI   = 3'd5,
    ADR_FLAGS  = 3'd6,
    ADR_IEN    = 3'd7
  } regAddr_e;

  typedef enum logic [2:0] {
    RD_IDLE,
    RD_LOW,
    RD_TEMP,
    RD_FLAGS,
    RD_IEN
  } rdKind_e;

  typedef struct packed {
    logic              tempFromBus;
    logic              tempFromReg;
    logic [SEL_W-1:0]  wordSel;
    logic              cntLoad;
    logic [NUM_CH-1:0] cmpLoad;
    logic              flagClr;
    logic              ienLoad;
    rdKind_e           rdKind;
  } strobes_t;
endpackage

// File: rtl/cmpTimerCtrl.sv
module cmpTimerCtrl
  import cmpTimerPkg::*;
(
  input  logic              busWr,
  input  logic              busRd,
  input  logic [ADDR_W-1:0] busAddr,
  output strobes_t          st
);
  regAddr_e addr;
  assign addr = regAddr_e'(busAddr);

  always_comb begin
    st = '0;
    st.rdKind = RD_IDLE;
    st.wordSel = busAddr[ADDR_W-1:1];
    if (busWr) begin
      unique case (addr)
        ADR_CNT_HI, ADR_A_HI, ADR_B_HI: st.tempFromBus = 1'b1;
        ADR_CNT_LO: st.cntLoad = 1'b1;
        ADR_A_LO:   st.cmpLoad[0] = 1'b1;
        ADR_B_LO:   st.cmpLoad[1] = 1'b1;
        ADR_FLAGS:  st.flagClr = 1'b1;
        ADR_IEN:    st.ienLoad = 1'b1;
        default: ;
      endcase
    end
    if (busRd) begin
      unique case (addr)
        ADR_CNT_LO, ADR_A_LO, ADR_B_LO: begin
          st.tempFromReg = 1'b1;
          st.rdKind = RD_LOW;
        end
        ADR_CNT_HI, ADR_A_HI, ADR_B_HI: st.rdKind = RD_TEMP;
        ADR_FLAGS: st.rdKind = RD_FLAGS;
        ADR_IEN:   st.rdKind = RD_IEN;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/cmpTimerDatapath.sv
module cmpTimerDatapath
  import cmpTimerPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic [BYTE_W-1:0] busWdata,
  input  strobes_t          st,
  output logic [BYTE_W-1:0] busRdata,
  output logic [NUM_CH-1:0] waveQ,
  output logic [NUM_CH-1:0] irqOut,
  output logic [WORD_W-1:0] cntQ,
  output logic [BYTE_W-1:0] tempQ,
  output logic              blockQ,
  output logic [NUM_CH-1:0] flagQ
);
  logic [WORD_W-1:0] cmpQ [NUM_CH];
  logic [NUM_CH-1:0] ienQ;
  logic [WORD_W-1:0] selWord;
  logic              compareEn;
  logic [WORD_W-1:0] loadWord;

  assign loadWord  = {tempQ, busWdata};
  assign compareEn = tick && !st.cntLoad && !blockQ;

  always_comb begin
    selWord = cntQ;
    for (int i = 0; i < NUM_CH; i++)
      if (int'(st.wordSel) == i + 1) selWord = cmpQ[i];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ   <= '0;
      blockQ <= 1'b0;
    end else begin
      if (st.cntLoad) cntQ <= loadWord;
      else if (tick)  cntQ <= cntQ + WORD_W'(1);
      if (st.cntLoad) blockQ <= 1'b1;
      else if (tick)  blockQ <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                tempQ <= '0;
    else if (st.tempFromBus)  tempQ <= busWdata;
    else if (st.tempFromReg)  tempQ <= selWord[WORD_W-1:BYTE_W];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           ienQ <= '0;
    else if (st.ienLoad) ienQ <= busWdata[NUM_CH-1:0];
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    logic hit;
    assign hit = compareEn && (cntQ == cmpQ[ch]);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        cmpQ[ch]  <= '0;
        flagQ[ch] <= 1'b0;
        waveQ[ch] <= 1'b0;
      end else begin
        if (st.cmpLoad[ch]) cmpQ[ch] <= loadWord;
        if (hit)                                flagQ[ch] <= 1'b1;
        else if (st.flagClr && busWdata[ch])    flagQ[ch] <= 1'b0;
        if (hit) waveQ[ch] <= !waveQ[ch];
      end
    end
    assign irqOut[ch] = flagQ[ch] && ienQ[ch];
  end

  always_comb begin
    busRdata = '0;
    unique case (st.rdKind)
      RD_LOW:   busRdata = selWord[BYTE_W-1:0];
      RD_TEMP:  busRdata = tempQ;
      RD_FLAGS: busRdata[NUM_CH-1:0] = flagQ;
      RD_IEN:   busRdata[NUM_CH-1:0] = ienQ;
      default:  busRdata = '0;
    endcase
  end
endmodule

// File: rtl/cmpTimer16.sv
module cmpTimer16
  import cmpTimerPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              timerTick,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [BYTE_W-1:0] busWdata,
  output logic [BYTE_W-1:0] busRdata,
  output logic              waveA,
  output logic              waveB,
  output logic              irqA,
  output logic              irqB
);
  strobes_t          st;
  logic [NUM_CH-1:0] waveQ;
  logic [NUM_CH-1:0] irqOut;
  logic [WORD_W-1:0] cntQ;
  logic [BYTE_W-1:0] tempQ;
  logic              blockQ;
  logic [NUM_CH-1:0] flagQ;

  cmpTimerCtrl u_ctrl (
    .busWr   (busWr),
    .busRd   (busRd),
    .busAddr (busAddr),
    .st      (st)
  );

  cmpTimerDatapath u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .tick     (timerTick),
    .busWdata (busWdata),
    .st       (st),
    .busRdata (busRdata),
    .waveQ    (waveQ),
    .irqOut   (irqOut),
    .cntQ     (cntQ),
    .tempQ    (tempQ),
    .blockQ   (blockQ),
    .flagQ    (flagQ)
  );

  assign waveA = waveQ[0];
  assign waveB = waveQ[1];
  assign irqA  = irqOut[0];
  assign irqB  = irqOut[1];
endmodule

// File: rtl/cmpTimer16Check.sv
module cmpTimer16Check
  import cmpTimerPkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              timerTick,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWr,
  input logic [BYTE_W-1:0] busWdata,
  input logic              waveA,
  input logic              waveB,
  input strobes_t          st,
  input logic [WORD_W-1:0] cntQ,
  input logic [BYTE_W-1:0] tempQ,
  input logic              blockQ,
  input logic [NUM_CH-1:0] flagQ
);
  p_count_inc_r2: assert property (@(posedge clk) disable iff (!rstN)
    timerTick && !st.cntLoad |=> cntQ == $past(cntQ) + WORD_W'(1));

  p_count_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !timerTick && !st.cntLoad |=> $stable(cntQ));

  p_count_load_r6: assert property (@(posedge clk) disable iff (!rstN)
    st.cntLoad |=> cntQ == $past({tempQ, busWdata}));

  p_single_load_r3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({st.cntLoad, st.cmpLoad, st.tempFromBus}));

  p_temp_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    !st.tempFromBus && !st.tempFromReg |=> $stable(tempQ));

  p_wave_flag_r7: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(waveA) |-> flagQ[0]);

  p_blocked_tick_r8: assert property (@(posedge clk) disable iff (!rstN)
    blockQ && timerTick && !st.cntLoad |=> $stable(waveA) && $stable(waveB));

  p_flag_clear_r9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(flagQ[0]) |-> $past(busWr && busAddr == ADR_FLAGS && busWdata[0]));
endmodule

bind cmpTimer16 cmpTimer16Check u_check (
  .clk       (clk),
  .rstN      (rstN),
  .timerTick (timerTick),
  .busAddr   (busAddr),
  .busWr     (busWr),
  .busWdata  (busWdata),
  .waveA     (waveA),
  .waveB     (waveB),
  .st        (st),
  .cntQ      (cntQ),
  .tempQ     (tempQ),
  .blockQ    (blockQ),
  .flagQ     (flagQ)
);

// File: tb/cmpTimer16_test.sv
module cmpTimer16_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       timerTick = 1'b0;
  logic [2:0] busAddr = '0;
  logic       busWr = 1'b0;
  logic       busRd = 1'b0;
  logic [7:0] busWdata = '0;
  logic [7:0] busRdata;
  logic       waveA, waveB, irqA, irqB;

  always #10 clk = ~clk;

  cmpTimer16 uut (
    .clk(clk), .rstN(rstN), .timerTick(timerTick), .busAddr(busAddr),
    .busWr(busWr), .busRd(busRd), .busWdata(busWdata), .busRdata(busRdata),
    .waveA(waveA), .waveB(waveB), .irqA(irqA), .irqB(irqB)
  );

  int checks = 0;
  int errors = 0;
  int lastRd = 0;

  // behavioural reference state
  int mCnt = 0, mTemp = 0, mBlock = 0;
  int mCmp[2] = '{0, 0};
  int mFlag[2] = '{0, 0};
  int mWave[2] = '{0, 0};
  int mIen[2] = '{0, 0};

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int wordOf(int a);
    if (a < 2) return mCnt;
    if (a < 4) return mCmp[0];
    return mCmp[1];
  endfunction

  function automatic int modelRead(int a);
    case (a)
      0, 2, 4: return wordOf(a) & 'hFF;
      1, 3, 5: return mTemp;
      6:       return mFlag[0] | (mFlag[1] << 1);
      default: return mIen[0] | (mIen[1] << 1);
    endcase
  endfunction

  task automatic modelStep(bit tk, bit wr, bit rd, int a, int d);
    int hit[2];
    int nextTemp = mTemp;
    bit cntLd = wr && a == 0;
    for (int c = 0; c < 2; c++)
      hit[c] = (tk && !cntLd && !mBlock && mCnt == mCmp[c]) ? 1 : 0;
    if (wr && (a == 1 || a == 3 || a == 5)) nextTemp = d;
    else if (rd && (a == 0 || a == 2 || a == 4)) nextTemp = wordOf(a) >> 8;
    if (cntLd) mBlock = 1; else if (tk) mBlock = 0;
    if (cntLd) mCnt = (mTemp << 8) | d;
    else if (tk) mCnt = (mCnt + 1) & 'hFFFF;
    if (wr && a == 2) mCmp[0] = (mTemp << 8) | d;
    if (wr && a == 4) mCmp[1] = (mTemp << 8) | d;
    for (int c = 0; c < 2; c++) begin
      if (hit[c] != 0) mFlag[c] = 1;
      else if (wr && a == 6 && ((d >> c) & 1) != 0) mFlag[c] = 0;
      mWave[c] ^= hit[c];
      if (wr && a == 7) mIen[c] = (d >> c) & 1;
    end
    mTemp = nextTemp;
  endtask

  // one bus cycle: drive after falling edge, compare outputs every clock
  task automatic cyc(bit tk, bit wr, bit rd, int a, int d);
    timerTick = tk; busWr = wr; busRd = rd;
    busAddr = 3'(a); busWdata = 8'(d);
    #1;
    if (rd) begin
      lastRd = int'(busRdata);
      check("R4 read data", lastRd, modelRead(a));
    end
    @(posedge clk);
    modelStep(tk, wr, rd, a, d);
    @(negedge clk);
    timerTick = 0; busWr = 0; busRd = 0;
    check("R7 waveA", int'(waveA), mWave[0]);
    check("R7 waveB", int'(waveB), mWave[1]);
    check("R10 irqA", int'(irqA), mFlag[0] & mIen[0]);
    check("R10 irqB", int'(irqB), mFlag[1] & mIen[1]);
  endtask

  task automatic idle(int n, bit tk);
    for (int i = 0; i < n; i++) cyc(tk, 0, 0, 0, 0);
  endtask

  task automatic wr16(int lo, int val);
    cyc(0, 1, 0, lo + 1, (val >> 8) & 'hFF);
    cyc(0, 1, 0, lo, val & 'hFF);
  endtask

  task automatic expectWord(int lo, int exp, string req);
    int b0;
    cyc(0, 0, 1, lo, 0);
    b0 = lastRd;
    cyc(0, 0, 1, lo + 1, 0);
    check(req, (lastRd << 8) | b0, exp);
  endtask

  task automatic expectReg(int a, int exp, string req);
    cyc(0, 0, 1, a, 0);
    check(req, lastRd, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    check("R1 waveA", int'(waveA), 0);
    check("R1 irqB", int'(irqB), 0);
    expectReg(1, 0, "R1 holding byte");
    expectWord(0, 0, "R1 counter");
    expectWord(2, 0, "R1 compare A");
    expectWord(4, 0, "R1 compare B");
    expectReg(6, 0, "R1 flags");
    expectReg(7, 0, "R1 enables");

    // R3 high-then-low commit, high write alone changes nothing
    wr16(2, 'h0010);
    wr16(4, 'h0105);
    expectWord(2, 'h0010, "R3 compare A load");
    cyc(0, 1, 0, 3, 'hAB);
    idle(1, 0);
    expectWord(2, 'h0010, "R3 high write alone");
    expectWord(4, 'h0105, "R3 compare B load");

    // R2/R7 free run through both matches
    idle(300, 1);
    expectWord(0, 300, "R2 count");
    check("R7 waveA toggled", int'(waveA), 1);
    check("R7 waveB toggled", int'(waveB), 1);
    expectReg(6, 3, "R7 flags");
    idle(4, 0);
    expectWord(0, 300, "R2 hold without tick");

    // R4 snapshot across carry
    wr16(0, 'h01FF);
    cyc(1, 0, 1, 0, 0);
    check("R4 low byte before carry", lastRd, 'hFF);
    cyc(0, 0, 1, 1, 0);
    check("R4 high byte snapshot", lastRd, 'h01);
    expectWord(0, 'h0200, "R4 counter after tick");

    // R5 shared holding byte
    cyc(0, 1, 0, 3, 'h12);
    cyc(0, 1, 0, 0, 'h34);
    expectWord(0, 'h1234, "R5 cross-register write");
    expectWord(2, 'h0010, "R5 compare A untouched");
    cyc(0, 0, 1, 4, 0);
    expectReg(1, 'h01, "R5 cross-register read");

    // R6 write beats tick
    cyc(0, 1, 0, 1, 'h40);
    cyc(1, 1, 0, 0, 'h00);
    expectWord(0, 'h4000, "R6 write priority");

    // R8 blocked tick
    cyc(0, 1, 0, 6, 3);
    wr16(2, 'h2000);
    wr16(4, 'h2000);
    wr16(0, 'h2000);
    idle(3, 1);
    expectReg(6, 0, "R8 match removed");
    wr16(0, 'h1FFF);
    idle(2, 1);
    expectReg(6, 3, "R8 later match kept");

    // R9 clear semantics
    cyc(0, 1, 0, 6, 2);
    expectReg(6, 1, "R9 clear B only");
    cyc(0, 1, 0, 6, 0);
    expectReg(6, 1, "R9 zero write ignored");
    wr16(2, 'h3000);
    wr16(0, 'h2FFE);
    idle(2, 1);
    cyc(1, 1, 0, 6, 1);
    expectReg(6, 1, "R9 set wins over clear");
    cyc(0, 1, 0, 6, 1);
    expectReg(6, 0, "R9 clear A");

    // R10 interrupt gating
    cyc(0, 1, 0, 7, 3);
    expectReg(7, 3, "R10 enable readback");
    wr16(0, 'h2FFF);
    idle(2, 1);
    check("R10 irqA asserted", int'(irqA), 1);
    check("R10 irqB quiet", int'(irqB), 0);
    cyc(0, 1, 0, 7, 2);
    check("R10 irqA masked", int'(irqA), 0);

    // R2 wrap
    wr16(0, 'hFFFE);
    idle(3, 1);
    expectWord(0, 1, "R2 wrap");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule